// File: doc/BRIEF.md
# USB Device Controller Start-Up Sequencer

This block brings a full-speed USB device controller from its post-reset condition to the point where the host can see it on the bus. It is a hardware state machine that drives one simple register bus. On a start request it releases the controller's reset line and polls for the reset-done indication, giving up after a bounded number of reads. It then zeroes every word of the 4 KiB packet memory, so that endpoint and buffer control words begin in a known state. Last, it writes the five controller configuration registers in a fixed order.

Each bus request (read or write) is held steady until the bus acknowledges it. After that one step is complete and the machine moves on. When the final write is acknowledged, the block raises a one-cycle `done` pulse and then holds `ready`. If the reset-done poll times out, the block holds `error` instead and stops using the bus.

The states and their transitions are:
- ST_IDLE goes to ST_UNRESET on `start`.
- ST_UNRESET goes to ST_POLL on ack.
- ST_POLL goes to ST_WIPE on an ack whose data has bit 28 set. It goes to ST_FAULT on the last allowed not-done ack. Otherwise it stays in ST_POLL.
- ST_WIPE goes to ST_PHYMUX on the ack of the last word.
- ST_PHYMUX goes to ST_VBUS, ST_VBUS to ST_ENABLE, ST_ENABLE to ST_PULLUP, ST_PULLUP to ST_IRQEN, and ST_IRQEN to ST_READY, each on ack.
- ST_READY and ST_FAULT are terminal until reset.

Top module: `usbc_bringup_seq`

## Requirements
- R1: After reset, `bus_req`, `done`, `ready` and `error` are 0, and no bus request is made until `start` is seen in the idle state.
- R2: The first transaction is a write of 0x1000_0000 (bit 28) to address 0x4002_3000, which is the reset block base 0x4002_0000 plus the clear alias offset 0x3000.
- R3: Next, reads of 0x4002_0008 repeat until one returns read data with bit 28 set. Other data bits are ignored. A set bit 28 on the last allowed read still counts as success.
- R4: If 64 reads (POLL_LIMIT) all return bit 28 clear, the block holds `error`=1 and `ready`=0 and issues no further bus requests.
- R5: After a successful poll, the block writes 0 to each of the 1024 words at 0x5010_0000 + 4*i, with i ascending from 0 to 1023.
- R6: Next, the block writes 0x0000_0009 to 0x5011_0074. This is PHY routing in bit 0 plus software connect control in bit 3.
- R7: Next, the block writes 0x0000_000C to 0x5011_0078. This is VBUS-detect in bit 2 plus its override enable in bit 3.
- R8: Next, the block writes 0x0000_0001 to 0x5011_0040. This is the controller enable in bit 0, with the host-select bit 1 held at 0.
- R9: Next, the block writes 0x2001_0000 to 0x5011_004C. This is pull-up in bit 16 plus the EP0 single-buffer interrupt in bit 29.
- R10: The last transaction writes 0x0001_1010 to 0x5011_0090. It sets setup-request in bit 16, buffer-status in bit 4 and bus-reset in bit 12, and no other interrupt bits.
- R11: A bus request keeps its address, direction and data unchanged until it is acknowledged. Each acknowledge completes exactly one transaction.
- R12: `done` is high for exactly one cycle, in the cycle after the edge that samples the final ack. `ready` rises in the same cycle and stays high.
- R13: `start` has no effect outside the idle state. The transaction sequence and the single `done` pulse are unchanged, and no new transaction follows `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin the sequence (honoured in idle only) |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge completing the current transaction |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Held high once the sequence has completed |
| error | output | 1 | Held high after a reset-done poll timeout |

## Verification
A bus transaction takes effect at the clock edge that samples `bus_ack`. The next request's address and data are visible in the following cycle. `done` and `ready` also appear in the cycle after the edge that samples the final ack, and `error` appears in the cycle after the 64th not-done read is acknowledged.

The bench's bus responder raises `ack` at a falling edge after a random delay of zero to two cycles. It checks each request against the expected sequence at that moment. The monitor samples `done` at every falling edge and checks that the pulse lands exactly one cycle after the final ack. The terminal levels and the absence of further traffic are checked over a quiet window after the end.

// File: rtl/usbc_bringup_pkg.sv
package usbc_bringup_pkg;

    localparam int BUS_AW = 32;
    localparam int BUS_DW = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNRESET,
        ST_POLL,
        ST_WIPE,
        ST_PHYMUX,
        ST_VBUS,
        ST_ENABLE,
        ST_PULLUP,
        ST_IRQEN,
        ST_READY,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic              active;
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } bus_op_t;

endpackage

// File: rtl/usbc_wipe_ctr.sv
module usbc_wipe_ctr #(
    parameter int WORDS = 1024,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step && (idx != LAST_IDX)) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == LAST_IDX);

endmodule

// File: rtl/usbc_poll_timer.sv
module usbc_poll_timer #(
    parameter int LIMIT = 64,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // High while the current read is the last one allowed.
    assign expired = (cnt >= CW'(LIMIT - 1));

endmodule

// File: rtl/usbc_step_decode.sv
module usbc_step_decode
    import usbc_bringup_pkg::*;
#(
    parameter int              IDX_W        = 10,
    parameter logic [31:0]     RST_BASE     = 32'h4002_0000,
    parameter logic [31:0]     CLR_ALIAS    = 32'h0000_3000,
    parameter logic [31:0]     DONE_OFS     = 32'h0000_0008,
    parameter int              RST_BIT      = 28,
    parameter logic [31:0]     MEM_BASE     = 32'h5010_0000,
    parameter logic [31:0]     REG_BASE     = 32'h5011_0000,
    parameter logic [31:0]     MUX_OFS      = 32'h74,
    parameter logic [31:0]     PWR_OFS      = 32'h78,
    parameter logic [31:0]     MAIN_OFS     = 32'h40,
    parameter logic [31:0]     SIE_OFS      = 32'h4C,
    parameter logic [31:0]     INTE_OFS     = 32'h90,
    parameter logic [31:0]     MUX_VAL      = 32'h0000_0009,
    parameter logic [31:0]     PWR_VAL      = 32'h0000_000C,
    parameter logic [31:0]     MAIN_VAL     = 32'h0000_0001,
    parameter logic [31:0]     SIE_VAL      = 32'h2001_0000,
    parameter logic [31:0]     INTE_VAL     = 32'h0001_1010
) (
    input  seq_state_e       state,
    input  logic [IDX_W-1:0] wipe_idx,
    output bus_op_t          op
);

    always_comb begin
        op = '0;
        unique case (state)
            ST_UNRESET: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = RST_BASE + CLR_ALIAS;
                op.data   = 32'd1 << RST_BIT;
            end
            ST_POLL: begin
                op.active = 1'b1;
                op.we     = 1'b0;
                op.addr   = RST_BASE + DONE_OFS;
            end
            ST_WIPE: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = MEM_BASE + (32'(wipe_idx) << 2);
            end
            ST_PHYMUX: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = REG_BASE + MUX_OFS;
                op.data   = MUX_VAL;
            end
            ST_VBUS: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = REG_BASE + PWR_OFS;
                op.data   = PWR_VAL;
            end
            ST_ENABLE: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = REG_BASE + MAIN_OFS;
                op.data   = MAIN_VAL;
            end
            ST_PULLUP: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = REG_BASE + SIE_OFS;
                op.data   = SIE_VAL;
            end
            ST_IRQEN: begin
                op.active = 1'b1;
                op.we     = 1'b1;
                op.addr   = REG_BASE + INTE_OFS;
                op.data   = INTE_VAL;
            end
            default: op = '0;
        endcase
    end

endmodule

// File: rtl/usbc_bringup_seq.sv
module usbc_bringup_seq
    import usbc_bringup_pkg::*;
#(
    parameter int          MEM_BYTES  = 4096,
    parameter int          POLL_LIMIT = 64,
    parameter int          RST_BIT    = 28,
    parameter logic [31:0] RST_BASE   = 32'h4002_0000,
    parameter logic [31:0] MEM_BASE   = 32'h5010_0000,
    parameter logic [31:0] REG_BASE   = 32'h5011_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        done,
    output logic        ready,
    output logic        error
);

    localparam int WORDS = MEM_BYTES / 4;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    localparam logic [31:0] MUX_VAL  = (32'd1 << 0) | (32'd1 << 3);
    localparam logic [31:0] PWR_VAL  = (32'd1 << 2) | (32'd1 << 3);
    localparam logic [31:0] MAIN_VAL = (32'd1 << 0);
    localparam logic [31:0] SIE_VAL  = (32'd1 << 16) | (32'd1 << 29);
    localparam logic [31:0] INTE_VAL = (32'd1 << 16) | (32'd1 << 4) | (32'd1 << 12);

    seq_state_e       state_q, state_d;
    bus_op_t          op;
    logic [IDX_W-1:0] wipe_idx;
    logic             wipe_last;
    logic             poll_expired;
    logic             rst_seen;
    logic             done_q;

    assign rst_seen = bus_rdata[RST_BIT];

    usbc_wipe_ctr #(.WORDS(WORDS)) u_wipe (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .step  ((state_q == ST_WIPE) && bus_ack),
        .idx   (wipe_idx),
        .last  (wipe_last)
    );

    usbc_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_IDLE),
        .tick    ((state_q == ST_POLL) && bus_ack && !rst_seen),
        .expired (poll_expired)
    );

    usbc_step_decode #(
        .IDX_W    (IDX_W),
        .RST_BASE (RST_BASE),
        .RST_BIT  (RST_BIT),
        .MEM_BASE (MEM_BASE),
        .REG_BASE (REG_BASE),
        .MUX_VAL  (MUX_VAL),
        .PWR_VAL  (PWR_VAL),
        .MAIN_VAL (MAIN_VAL),
        .SIE_VAL  (SIE_VAL),
        .INTE_VAL (INTE_VAL)
    ) u_decode (
        .state    (state_q),
        .wipe_idx (wipe_idx),
        .op       (op)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   state_d = ST_UNRESET;
            ST_UNRESET: if (bus_ack) state_d = ST_POLL;
            ST_POLL: begin
                if (bus_ack) begin
                    if (rst_seen)          state_d = ST_WIPE;
                    else if (poll_expired) state_d = ST_FAULT;
                end
            end
            ST_WIPE:    if (bus_ack && wipe_last) state_d = ST_PHYMUX;
            ST_PHYMUX:  if (bus_ack) state_d = ST_VBUS;
            ST_VBUS:    if (bus_ack) state_d = ST_ENABLE;
            ST_ENABLE:  if (bus_ack) state_d = ST_PULLUP;
            ST_PULLUP:  if (bus_ack) state_d = ST_IRQEN;
            ST_IRQEN:   if (bus_ack) state_d = ST_READY;
            ST_READY:   state_d = ST_READY;
            ST_FAULT:   state_d = ST_FAULT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_IRQEN) && bus_ack;
    end

    // Combinational outputs
    always_comb begin
        bus_req   = op.active;
        bus_we    = op.we;
        bus_addr  = op.addr;
        bus_wdata = op.data;
        done      = done_q;
        ready     = (state_q == ST_READY);
        error     = (state_q == ST_FAULT);
    end

    // R11: an outstanding request is held unchanged until acknowledged
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R12: done lasts one cycle and coincides with ready
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);
    assert_ready_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (ready && !bus_req));
    assert_ready_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(bus_ack));

    // R4: a timeout holds error and silences the bus
    assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !ready && !bus_req));

endmodule

// File: tb/usbc_bringup_seq_bench.sv
`timescale 1ns/1ps
module usbc_bringup_seq_bench;

    localparam int LIMIT = 64;
    localparam int WORDS = 1024;
    localparam logic [31:0] RST_BASE = 32'h4002_0000;
    localparam logic [31:0] MEM_BASE = 32'h5010_0000;
    localparam logic [31:0] REG_BASE = 32'h5011_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bus_req, bus_we, bus_ack, done, ready, error;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    usbc_bringup_seq u_usbc_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .done(done), .ready(ready), .error(error)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int txn_idx  = 0;
    int polls    = 0;
    int exp_p    = 0;
    bit timeout_mode = 1'b0;
    int last_ack_cyc = -10;
    int done_cnt = 0;
    int done_cyc = -1;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected transaction: {we, addr, data}, and its requirement tag.
    function automatic logic [64:0] exp_txn(input int idx, input int p);
        int w0 = p + 2;
        if (idx == 0) return {1'b1, RST_BASE + 32'h3000, 32'h1000_0000};
        if (idx < w0) return {1'b0, RST_BASE + 32'h8, 32'h0};
        if (idx < w0 + WORDS) return {1'b1, MEM_BASE + 32'((idx - w0) * 4), 32'h0};
        case (idx - w0 - WORDS)
            0: return {1'b1, REG_BASE + 32'h74, 32'h0000_0009};
            1: return {1'b1, REG_BASE + 32'h78, 32'h0000_000C};
            2: return {1'b1, REG_BASE + 32'h40, 32'h0000_0001};
            3: return {1'b1, REG_BASE + 32'h4C, 32'h2001_0000};
            4: return {1'b1, REG_BASE + 32'h90, 32'h0001_1010};
            default: return '1;
        endcase
    endfunction

    function automatic string tag_of(input int idx, input int p);
        int w0 = p + 2;
        if (idx == 0) return "R2";
        if (idx < w0) return "R3";
        if (idx < w0 + WORDS) return "R5";
        case (idx - w0 - WORDS)
            0: return "R6";
            1: return "R7";
            2: return "R8";
            3: return "R9";
            4: return "R10";
            default: return "R13";
        endcase
    endfunction

    function automatic int total_txns(input int p);
        return p + 2 + WORDS + 5;
    endfunction

    // Bus responder: random latency, checks every request as it is acknowledged.
    initial begin
        int dly;
        logic [64:0] e;
        logic [64:0] got;
        bit ok;
        string tg;
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n && bus_req) begin
                got = {bus_we, bus_addr, bus_wdata};
                dly = $urandom_range(0, 2);
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    check(bus_req && ({bus_we, bus_addr, bus_wdata} == got), "R11",
                          64'({bus_we, bus_addr}), 64'({got[64], got[63:32]}));
                end
                if (timeout_mode) begin
                    if (txn_idx == 0) begin
                        e = exp_txn(0, 0); tg = "R2";
                    end else if (txn_idx <= LIMIT) begin
                        e = exp_txn(1, 0); tg = "R4";
                    end else begin
                        e = '1; tg = "R4";
                    end
                end else begin
                    e  = (txn_idx < total_txns(exp_p)) ? exp_txn(txn_idx, exp_p) : '1;
                    tg = tag_of(txn_idx, exp_p);
                end
                ok = (got[64:32] == e[64:32]) && (!e[64] || got[31:0] == e[31:0]);
                check(ok, tg, got[63:0], e[63:0]);
                bus_rdata = $urandom & ~(32'd1 << 28);
                if (!got[64]) begin
                    if (!timeout_mode && polls >= exp_p) bus_rdata[28] = 1'b1;
                    polls++;
                end
                txn_idx++;
                last_ack_cyc = cyc;
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
            end
        end
    end

    // done monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        txn_idx = 0; polls = 0; done_cnt = 0; done_cyc = -1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: quiet after reset without start
        check(!bus_req && !done && !ready && !error, "R1",
              64'({bus_req, done, ready, error}), 64'h0);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input bit poke);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (poke && (i == 1500 || i == 40)) pulse_start();
            if (ready || error) break;
        end
    endtask

    task automatic run_ok(input int p, input bit poke);
        int n_after;
        do_reset();
        timeout_mode = 1'b0;
        exp_p = p;
        pulse_start();
        wait_end(poke);
        check(ready && !error, "R12", 64'({ready, error}), 64'h2);
        check(txn_idx == total_txns(p), "R10", 64'(txn_idx), 64'(total_txns(p)));
        check(done_cnt == 1, "R12", 64'(done_cnt), 64'd1);
        check(done_cyc == last_ack_cyc + 1, "R12", 64'(done_cyc), 64'(last_ack_cyc + 1));
        n_after = txn_idx;
        pulse_start();
        repeat (20) @(negedge clk);
        check(txn_idx == n_after && ready && !bus_req && done_cnt == 1, "R13",
              64'(txn_idx), 64'(n_after));
    endtask

    task automatic run_timeout();
        do_reset();
        timeout_mode = 1'b1;
        pulse_start();
        wait_end(1'b0);
        check(error && !ready, "R4", 64'({error, ready}), 64'h2);
        check(txn_idx == LIMIT + 1, "R4", 64'(txn_idx), 64'(LIMIT + 1));
        pulse_start();
        repeat (30) @(negedge clk);
        check(txn_idx == LIMIT + 1 && !bus_req && error && done_cnt == 0, "R4",
              64'(txn_idx), 64'(LIMIT + 1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        run_ok(0, 1'b0);                 // done on first poll
        run_ok(LIMIT - 1, 1'b0);         // done on last allowed poll (R3 boundary)
        run_ok(3, 1'b1);                 // start pokes while busy (R13)
        for (int r = 0; r < 3; r++) run_ok($urandom_range(0, 10), 1'b0);
        run_timeout();                   // R4
        finish_run();
    end

endmodule